// File: doc/BRIEF.md
# Keystream-Masked Read Data Flow Controller

This block sits on a 64-bit read response path between a slave (typically an external memory controller) and a master. For read bursts that a neighbouring region decoder marks as encrypted, it XORs every returning beat with half of a 128-bit keystream word. One keystream word covers one 16-byte block, which is two beats. It watches read-address handshakes and walks the address of each beat. It asks an external keystream generator for one word per block through a request/response port. The words come back in order, a fixed number of cycles later.

To hide the generator latency, the block keeps a small FIFO of keystream words for consecutive blocks that follow the block currently needed. A beat whose word is at the FIFO head passes with no added latency. When the needed block is not at the head of the precomputed sequence, the block holds the slave-side ready low. This happens on a non-contiguous address, a change of region, or a cold start. The block then discards the old sequence, including responses still in flight, and restarts the sequence at the needed block. Bursts that are not encrypted pass through unchanged and without stalls.

The controller is a four-state machine:
- ST_IDLE means no burst is open.
- ST_PASS is a clear-text burst.
- ST_DECRYPT is an encrypted burst.
- ST_RESYNC is a one-cycle flush that realigns the keystream sequence.

Its transitions are:
- ST_IDLE goes to ST_PASS on a handshake of a clear address, and to ST_DECRYPT on a handshake of an encrypted address.
- ST_PASS returns to ST_IDLE when the beat marked last is taken.
- ST_DECRYPT goes to ST_RESYNC when the head of the precomputed sequence does not match the needed block or region. Otherwise it returns to ST_IDLE when the last beat is taken.
- ST_RESYNC always goes to ST_DECRYPT.

Only one burst is open at a time. The master issues a new address only after the previous last beat has been taken.

Top module: `kmask_flow`

## Requirements
- R1: During and right after reset, `s_rready`, `m_rvalid` and `ks_req_valid` are low.
- R2: For a burst with `ar_cipher` low, `m_rdata` equals `s_rdata`, `m_rvalid` follows `s_rvalid` and `s_rready` follows `m_rready` in the same cycle, so no stall cycle is added.
- R3: For an encrypted burst, each forwarded beat equals `s_rdata` XOR a keystream half. The half is bits 63:0 of the block's word when address bit 3 of the beat is 0, and bits 127:64 when it is 1.
- R4: While the keystream word for the current encrypted beat is not held, `s_rready` and `m_rvalid` are low.
- R5: Each keystream request carries a counter with the following fields. The low 4 bits are zero. Bits 31:4 are the block address (beat address bits 31:4). Bits 47:32 are the region id, zero-extended from 2 bits. Bits 63:48 are the firmware version. Bits 127:64 are the 64-bit region nonce.
- R6: Requests are issued for consecutive block addresses, starting at the needed block. Words held plus requests outstanding never exceed FIFO_DEPTH (4), and requesting stops when that limit is reached.
- R7: A following burst whose blocks are already in the FIFO is forwarded with zero stall cycles. This covers a burst that starts in the same or the next block.
- R8: A burst whose block or region does not match the precomputed sequence stalls until a fresh word arrives. Responses that belong to the discarded sequence are never used.
- R9: Beat addresses advance by 8 bytes and never leave the 4 KB page of the start address. Incrementing bursts (any `ar_burst` other than 2'b10) continue at the page start after the page end. Wrapping bursts (`ar_burst` = 2'b10) wrap inside a window of (len+1)*8 bytes.
- R10: `m_rlast` follows `s_rlast`. After the last beat is taken the block returns to idle, where a stray `s_rvalid` sees `s_rready` and `m_rvalid` low.
- R11: A beat is taken from the slave only when `s_rvalid` and `m_rready` are high and its keystream is available, and it is presented to the master in that same cycle. With `m_rready` low, `s_rready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ar_valid | input | 1 | Read address valid (observed) |
| ar_ready | input | 1 | Read address ready (observed) |
| ar_addr | input | 32 | Read start address |
| ar_len | input | 8 | Beats in burst minus one |
| ar_burst | input | 2 | Burst kind, 2'b10 wrap, else incrementing |
| ar_cipher | input | 1 | Address hits an enabled encrypted region |
| ar_region | input | 2 | Region id of the hit |
| ar_nonce | input | 64 | Nonce of the hit region |
| ar_version | input | 16 | Firmware version of the hit region |
| s_rvalid | input | 1 | Slave beat valid |
| s_rready | output | 1 | Ready toward slave |
| s_rdata | input | 64 | Slave beat data |
| s_rlast | input | 1 | Slave last beat |
| m_rvalid | output | 1 | Beat valid toward master |
| m_rready | input | 1 | Master ready |
| m_rdata | output | 64 | Forwarded, unmasked data |
| m_rlast | output | 1 | Last beat toward master |
| ks_req_valid | output | 1 | Keystream request |
| ks_req_ctr | output | 128 | Counter block for the request |
| ks_rsp_valid | input | 1 | Keystream word returned (in order) |
| ks_rsp_word | input | 128 | Keystream word |

## Verification
Two functions can fall in the same cycle:
- A beat that takes the last half of the FIFO head pops the head, and that same pop frees a credit for a new prefetch request.
- A resynchronisation flushes the FIFO while earlier prefetch responses are still coming back from the generator.

The bench provokes the first with a contiguous burst that starts on an odd half, right after a prefetch run. It provokes the second by issuing a far, non-contiguous burst and a region change straight after that, while requests are still in flight. Both are judged by the exact XOR value of every forwarded beat against keystream words that the bench computes from the counter fields. A stale word used in place of a fresh one shows up as a data mismatch. The bench also counts stall cycles per burst.

// File: rtl/kmask_pkg.sv
package kmask_pkg;

    localparam int DATA_W = 64;
    localparam int KS_W   = 2 * DATA_W;
    localparam int ADDR_W = 32;
    localparam int BLK_W  = ADDR_W - 4;

    localparam logic [1:0] BURST_WRAP = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PASS,
        ST_DECRYPT,
        ST_RESYNC
    } flow_state_e;

    // Counter block: nonce | version | zero-extended region | block address | 4'b0
    function automatic logic [KS_W-1:0] build_ctr(
        input logic [63:0]      nonce,
        input logic [15:0]      version,
        input logic [1:0]       region,
        input logic [BLK_W-1:0] blk
    );
        return {nonce, version, 14'b0, region, blk, 4'b0};
    endfunction

endpackage

// File: rtl/kmask_ks_fifo.sv
module kmask_ks_fifo
    import kmask_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [KS_W-1:0]  push_word,
    input  logic             pop,
    output logic [KS_W-1:0]  head_word,
    output logic [CNT_W-1:0] count
);

    logic [KS_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= push_word;
    end

    assign head_word = mem[rd_ptr];

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (count < CNT_W'(DEPTH)));

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (count != '0));

endmodule

// File: rtl/kmask_beat_walker.sv
module kmask_beat_walker
    import kmask_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [7:0]        load_len,
    input  logic [1:0]        load_burst,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [PAGE_BITS-1:0] win_mask;
    logic [PAGE_BITS-1:0] off;
    logic [PAGE_BITS-1:0] off_inc;
    logic [31:0]          wrap_span;

    assign wrap_span = ((32'(load_len) + 32'd1) << 3) - 32'd1;
    assign off       = cur_addr[PAGE_BITS-1:0];
    assign off_inc   = off + PAGE_BITS'(8);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            win_mask <= '1;
        end else if (load) begin
            cur_addr <= {load_addr[ADDR_W-1:3], 3'b000};
            win_mask <= (load_burst == BURST_WRAP) ? wrap_span[PAGE_BITS-1:0] : '1;
        end else if (step) begin
            cur_addr <= {cur_addr[ADDR_W-1:PAGE_BITS], (off & ~win_mask) | (off_inc & win_mask)};
        end
    end

    assert_page_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cur_addr[ADDR_W-1:PAGE_BITS] == $past(cur_addr[ADDR_W-1:PAGE_BITS])));

    assert_beat_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_addr[2:0] == 3'b000);

endmodule

// File: rtl/kmask_flow.sv
module kmask_flow
    import kmask_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int INFLIGHT_W = 4,
    parameter int PAGE_BITS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid,
    input  logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [7:0]        ar_len,
    input  logic [1:0]        ar_burst,
    input  logic              ar_cipher,
    input  logic [1:0]        ar_region,
    input  logic [63:0]       ar_nonce,
    input  logic [15:0]       ar_version,
    input  logic              s_rvalid,
    output logic              s_rready,
    input  logic [DATA_W-1:0] s_rdata,
    input  logic              s_rlast,
    output logic              m_rvalid,
    input  logic              m_rready,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_rlast,
    output logic              ks_req_valid,
    output logic [KS_W-1:0]   ks_req_ctr,
    input  logic              ks_rsp_valid,
    input  logic [KS_W-1:0]   ks_rsp_word
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int SUM_W = INFLIGHT_W + 1;

    flow_state_e state, state_n;

    logic [1:0]        b_region;
    logic [63:0]       b_nonce;
    logic [15:0]       b_version;

    logic              ctx_valid;
    logic [1:0]        ctx_region;
    logic [63:0]       ctx_nonce;
    logic [15:0]       ctx_version;
    logic [BLK_W-1:0]  head_blk;
    logic [BLK_W-1:0]  req_blk;
    logic [INFLIGHT_W-1:0] keep_cnt;
    logic [INFLIGHT_W-1:0] drop_cnt;

    logic [ADDR_W-1:0] beat_addr;
    logic [BLK_W-1:0]  need_blk;
    logic              need_half;
    logic [KS_W-1:0]   head_word;
    logic [CNT_W-1:0]  fifo_count;
    logic [DATA_W-1:0] ks_mask;

    logic ar_fire, load, beat_take, last_take;
    logic ctx_match, ks_hit, credit_ok;
    logic fifo_push, fifo_pop, fifo_flush, rsp_kept;

    assign ar_fire   = ar_valid && ar_ready;
    assign load      = ar_fire && (state == ST_IDLE);
    assign beat_take = s_rvalid && s_rready;
    assign last_take = beat_take && s_rlast;
    assign need_blk  = beat_addr[ADDR_W-1:4];
    assign need_half = beat_addr[3];

    assign ctx_match = ctx_valid && (ctx_region == b_region) && (head_blk == need_blk);
    assign ks_hit    = ctx_match && (fifo_count != '0);
    assign credit_ok = (SUM_W'(fifo_count) + SUM_W'(keep_cnt)) < SUM_W'(FIFO_DEPTH);
    assign ks_mask   = need_half ? head_word[KS_W-1:DATA_W] : head_word[DATA_W-1:0];

    assign fifo_flush = (state == ST_RESYNC);
    assign rsp_kept   = ks_rsp_valid && (drop_cnt == '0);
    assign fifo_push  = rsp_kept && !fifo_flush;
    assign fifo_pop   = beat_take && (state == ST_DECRYPT) && need_half;

    kmask_beat_walker #(.PAGE_BITS(PAGE_BITS)) walker_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_addr  (ar_addr),
        .load_len   (ar_len),
        .load_burst (ar_burst),
        .step       (beat_take),
        .cur_addr   (beat_addr)
    );

    kmask_ks_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (fifo_push),
        .push_word (ks_rsp_word),
        .pop       (fifo_pop),
        .head_word (head_word),
        .count     (fifo_count)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (ar_fire) state_n = ar_cipher ? ST_DECRYPT : ST_PASS;
            ST_PASS:    if (last_take) state_n = ST_IDLE;
            ST_DECRYPT: begin
                if (!ctx_match)     state_n = ST_RESYNC;
                else if (last_take) state_n = ST_IDLE;
            end
            ST_RESYNC:  state_n = ST_DECRYPT;
            default:    state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        s_rready     = 1'b0;
        m_rvalid     = 1'b0;
        m_rdata      = '0;
        ks_req_valid = 1'b0;
        unique case (state)
            ST_PASS: begin
                s_rready = m_rready;
                m_rvalid = s_rvalid;
                m_rdata  = s_rdata;
                ks_req_valid = ctx_valid && credit_ok;
            end
            ST_DECRYPT: begin
                if (ks_hit) begin
                    s_rready = m_rready;
                    m_rvalid = s_rvalid;
                    m_rdata  = s_rdata ^ ks_mask;
                end
                ks_req_valid = ctx_valid && credit_ok && ctx_match;
            end
            ST_IDLE:   ks_req_valid = ctx_valid && credit_ok;
            ST_RESYNC: ks_req_valid = 1'b0;
            default:   ks_req_valid = 1'b0;
        endcase
    end

    assign m_rlast    = s_rlast;
    assign ks_req_ctr = build_ctr(ctx_nonce, ctx_version, ctx_region, req_blk);

    // Burst context captured at the address handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_region  <= '0;
            b_nonce   <= '0;
            b_version <= '0;
        end else if (load) begin
            b_region  <= ar_region;
            b_nonce   <= ar_nonce;
            b_version <= ar_version;
        end
    end

    // Keystream sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_valid   <= 1'b0;
            ctx_region  <= '0;
            ctx_nonce   <= '0;
            ctx_version <= '0;
            head_blk    <= '0;
            req_blk     <= '0;
            keep_cnt    <= '0;
            drop_cnt    <= '0;
        end else if (state == ST_RESYNC) begin
            ctx_valid   <= 1'b1;
            ctx_region  <= b_region;
            ctx_nonce   <= b_nonce;
            ctx_version <= b_version;
            head_blk    <= need_blk;
            req_blk     <= need_blk;
            keep_cnt    <= '0;
            drop_cnt    <= drop_cnt + keep_cnt - INFLIGHT_W'(ks_rsp_valid);
        end else begin
            if (ks_rsp_valid && (drop_cnt != '0)) drop_cnt <= drop_cnt - 1'b1;
            keep_cnt <= keep_cnt + INFLIGHT_W'(ks_req_valid) - INFLIGHT_W'(rsp_kept);
            if (ks_req_valid) req_blk  <= req_blk + 1'b1;
            if (fifo_pop)     head_blk <= head_blk + 1'b1;
        end
    end

    assert_stall_hides_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && m_rready && !s_rready) |-> !m_rvalid);

    assert_take_is_forwarded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && s_rready) |-> (m_rvalid && m_rready));

    assert_credit_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (SUM_W'(fifo_count) + SUM_W'(keep_cnt)) <= SUM_W'(FIFO_DEPTH));

    assert_resync_then_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESYNC) |=> ((state == ST_DECRYPT) && !s_rready));

    assert_rsp_expected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ks_rsp_valid |-> ((SUM_W'(keep_cnt) + SUM_W'(drop_cnt)) != '0));

    assert_idle_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!s_rready && !m_rvalid));

endmodule

// File: tb/kmask_flow_tb.sv
module kmask_flow_tb_top;

    localparam int LAT = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ar_valid = 0, ar_ready = 0, ar_cipher = 0;
    logic [31:0] ar_addr = '0;
    logic [7:0]  ar_len = '0;
    logic [1:0]  ar_burst = '0, ar_region = '0;
    logic [63:0] ar_nonce = '0;
    logic [15:0] ar_version = '0;
    logic s_rvalid = 0, s_rlast = 0, m_rready = 1;
    logic [63:0] s_rdata = '0;
    logic s_rready, m_rvalid, m_rlast, ks_req_valid, ks_rsp_valid;
    logic [63:0] m_rdata;
    logic [127:0] ks_req_ctr, ks_rsp_word;

    int nchecks = 0;
    int nerr = 0;
    int cycles = 0;
    bit done = 0;

    logic         pv [LAT];
    logic [127:0] pc [LAT];
    logic [127:0] req_log [64];
    int req_total = 0;

    always #4 clk = ~clk;

    function automatic logic [127:0] gen_word(input logic [127:0] c);
        logic [63:0] lo, hi;
        lo = (c[63:0] * 64'h9E3779B97F4A7C15) ^ c[127:64];
        hi = (c[127:64] * 64'hC2B2AE3D27D4EB4F) ^ c[63:0];
        return {hi, lo};
    endfunction

    function automatic logic [127:0] ctr_of(input logic [31:0] a, input logic [1:0] rg,
                                            input logic [63:0] nc, input logic [15:0] vr);
        return {nc, vr, 14'b0, rg, a[31:4], 4'b0};
    endfunction

    function automatic logic [63:0] ks_half(input logic [31:0] a, input logic [1:0] rg,
                                            input logic [63:0] nc, input logic [15:0] vr);
        logic [127:0] k;
        k = gen_word(ctr_of(a, rg, nc, vr));
        return a[3] ? k[127:64] : k[63:0];
    endfunction

    // Keystream generator model: fixed latency, in order, one per cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) pv[i] <= 1'b0;
        end else begin
            pv[0] <= ks_req_valid;
            pc[0] <= ks_req_ctr;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1];
                pc[i] <= pc[i-1];
            end
            if (ks_req_valid) begin
                req_log[req_total % 64] = ks_req_ctr;
                req_total++;
            end
        end
    end
    assign ks_rsp_valid = pv[LAT-1] === 1'b1;
    assign ks_rsp_word  = gen_word(pc[LAT-1]);

    kmask_flow dut_i (
        .clk(clk), .rst_n(rst_n),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
        .ar_burst(ar_burst), .ar_cipher(ar_cipher), .ar_region(ar_region),
        .ar_nonce(ar_nonce), .ar_version(ar_version),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rlast(s_rlast),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rlast(m_rlast),
        .ks_req_valid(ks_req_valid), .ks_req_ctr(ks_req_ctr),
        .ks_rsp_valid(ks_rsp_valid), .ks_rsp_word(ks_rsp_word)
    );

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic run_burst(input logic [31:0] a0, input int len, input logic [1:0] bt,
                             input logic cip, input logic [1:0] rg, input logic [63:0] nc,
                             input logic [15:0] vr, input bit bp, input string tag,
                             output int stalls);
        logic [31:0] a, wmask;
        int cyc;
        stalls = 0;
        cyc = 0;
        a = {a0[31:3], 3'b000};
        wmask = (bt == 2'b10) ? (((len + 1) << 3) - 1) : 32'hFFF;
        @(negedge clk);
        ar_addr = a0; ar_len = 8'(len); ar_burst = bt; ar_cipher = cip;
        ar_region = rg; ar_nonce = nc; ar_version = vr;
        ar_valid = 1; ar_ready = 1;
        @(negedge clk);
        ar_valid = 0; ar_ready = 0;
        for (int i = 0; i <= len; i++) begin
            logic [63:0] d, ex;
            bit taken;
            d = {a, ~a};
            ex = cip ? (d ^ ks_half(a, rg, nc, vr)) : d;
            s_rvalid = 1; s_rdata = d; s_rlast = (i == len);
            taken = 0;
            while (!taken) begin
                m_rready = bp ? (cyc % 2 == 0) : 1'b1;
                #1;
                if (!m_rready) begin
                    chk(s_rready == 1'b0, {tag, " R11 s_rready with master not ready"}, s_rready, 0);
                end else if (s_rready) begin
                    chk(m_rvalid == 1'b1, {tag, " R11 m_rvalid on take"}, m_rvalid, 1);
                    chk(m_rdata == ex, {tag, cip ? " R3 masked data" : " R2 clear data"}, m_rdata, ex);
                    chk(m_rlast == (i == len), {tag, " R10 rlast"}, m_rlast, (i == len));
                    taken = 1;
                end else begin
                    stalls++;
                    chk(m_rvalid == 1'b0, {tag, " R4 m_rvalid during stall"}, m_rvalid, 0);
                end
                cyc++;
                @(negedge clk);
            end
            a = {a[31:12], (a[11:0] & ~wmask[11:0]) | ((a[11:0] + 12'd8) & wmask[11:0])};
        end
        s_rvalid = 0; s_rlast = 0; m_rready = 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            nchecks++;
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    localparam logic [63:0] NA = 64'h0123456789ABCDEF;
    localparam logic [63:0] NB = 64'hFEDCBA9876543210;
    localparam logic [15:0] VA = 16'h00A5;
    localparam logic [15:0] VB = 16'h1C3E;

    initial begin
        int st;
        int base;
        logic [27:0] bb;
        repeat (3) @(negedge clk);
        #1;
        chk(s_rready == 0 && m_rvalid == 0 && ks_req_valid == 0, "R1 outputs in reset",
            {s_rready, m_rvalid, ks_req_valid}, 0);
        rst_n = 1;
        @(negedge clk); #1;
        chk(s_rready == 0 && m_rvalid == 0 && ks_req_valid == 0, "R1 outputs after reset",
            {s_rready, m_rvalid, ks_req_valid}, 0);

        // Clear burst
        run_burst(32'h1000_0000, 7, 2'b01, 0, 2'd0, NA, VA, 0, "plain", st);
        chk(st == 0, "R2 plain burst stalls", st, 0);
        chk(req_total == 0, "R2 no keystream request for plain burst", req_total, 0);

        // Cold encrypted single beat
        base = req_total;
        run_burst(32'h9000_0100, 0, 2'b01, 1, 2'd0, NA, VA, 0, "cold", st);
        chk(st > 10, "R4 cold beat stalls for keystream", st, 11);
        idle(40);
        chk(req_total - base == 4, "R6 prefetch stops at depth", req_total - base, 4);
        chk(req_log[base % 64] == ctr_of(32'h9000_0100, 2'd0, NA, VA), "R5 counter format",
            req_log[base % 64], ctr_of(32'h9000_0100, 2'd0, NA, VA));
        bb = 28'h900_0010;
        for (int k = 1; k < 4; k++) begin
            chk(req_log[(base + k) % 64][31:4] == bb + 28'(k), "R6 consecutive block requests",
                req_log[(base + k) % 64][31:4], bb + 28'(k));
        end

        // Contiguous follow-up starting on the odd half: zero stall
        run_burst(32'h9000_0108, 4, 2'b01, 1, 2'd0, NA, VA, 0, "contig", st);
        chk(st == 0, "R7 contiguous burst stalls", st, 0);

        // Far address right away, prefetches still in flight
        idle(1);
        run_burst(32'h9004_0000, 7, 2'b01, 1, 2'd1, NB, VB, 0, "far", st);
        chk(st > 0, "R8 non-contiguous burst must stall", st, 1);

        // Next block but different region
        idle(1);
        run_burst(32'h9004_0040, 1, 2'b01, 1, 2'd2, NA, VB, 0, "region", st);
        chk(st > 0, "R8 region change must stall", st, 1);

        // Wrapping burst
        run_burst(32'h9005_0010, 3, 2'b10, 1, 2'd2, NA, VB, 0, "wrap", st);

        // Incrementing burst at page end stays in page
        run_burst(32'h9006_0FF8, 1, 2'b01, 1, 2'd2, NA, VB, 0, "page", st);

        // Master backpressure on a prefetched stream
        idle(40);
        run_burst(32'h9006_0008, 3, 2'b01, 1, 2'd2, NA, VB, 1, "bp", st);
        chk(st == 0, "R7 prefetched burst under backpressure stalls", st, 0);

        // Long cold burst
        run_burst(32'h9008_0200, 15, 2'b01, 1, 2'd3, NB, VA, 0, "long", st);

        // Stray beat in idle
        idle(2);
        s_rvalid = 1; s_rdata = 64'hDEAD; m_rready = 1;
        #1;
        chk(s_rready == 0 && m_rvalid == 0, "R10 idle ignores stray beat", {s_rready, m_rvalid}, 0);
        @(negedge clk);
        s_rvalid = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule